// File: doc/BRIEF.md
# DDR Mode Register Command Decoder

This block watches the command strobes, bank bits and address bus of a DDR SDRAM device model. It recognises load-mode commands and keeps two configuration registers. The base mode register holds burst length, burst ordering and CAS latency. The extended mode register holds the DLL on/off control and the output drive strength. The stored fields are decoded into ready-to-use outputs for the rest of the device model.

On a base-register write, the upper address bits choose what the command means. All zero means a normal parameter update. A8 set by itself means a parameter update plus a DLL reset request, which appears as a one-cycle pulse. Any other pattern is a reserved test mode: the register is left alone and a one-cycle error pulse is raised. The parameter `HI_ADDR_BIT` sets the highest address bit that takes part in this check: 11 for the smaller densities, 12 for the largest.

Top module: `ddr_mrs_decoder`

## Requirements
- R1: After reset, the outputs show burst length 4, sequential bursts, CAS latency 2 (`cas_lat_x2` = 4), DLL enabled, full drive strength, and both pulses low.
- R2: A command is a load-mode command only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at a rising clock edge. Any other strobe combination changes no output and raises no pulse.
- R3: A load-mode command with `ba` = 00 and A7 through A`HI_ADDR_BIT` all zero stores A0–A6 in the base register. A2:A0 sets burst length (001 = 2, 010 = 4, 011 = 8; every other code gives `burst_len` = 0). A3 sets burst type (0 = sequential, 1 = interleaved on `burst_seq`).
- R4: CAS latency comes from A6:A4 and is reported in half cycles on `cas_lat_x2`: 010 gives 4, 110 gives 5, 011 gives 6. Every other code gives 0 and sets `cl_invalid`.
- R5: A base-register write with A8 = 1 and every other bit from A7 through A`HI_ADDR_BIT` zero stores A0–A6. It also drives `dll_reset_pulse` high for exactly the one cycle after the command edge.
- R6: A base-register write with any other upper-bit pattern leaves the base register unchanged. It drives `reserved_err` high for exactly the one cycle after the command edge.
- R7: Address bits above `HI_ADDR_BIT` are ignored. With `HI_ADDR_BIT` = 11, A12 has no effect. With `HI_ADDR_BIT` = 12, A12 = 1 is a reserved pattern.
- R8: A load-mode command with `ba` = 01 writes the extended register. A0 = 0 enables the DLL (`dll_enable` = 1), and A1 = 1 selects reduced drive (`drive_reduced` = 1). The upper address bits are not checked, and the base register is unchanged.
- R9: A load-mode command with `ba[1]` = 1 writes neither register and raises no pulse.
- R10: Both registers hold their values across any number of cycles until they are written again or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank address, selects the target register |
| addr | input | ADDR_W | Address bus carrying the register value |
| burst_len | output | 4 | Burst length in beats (2, 4, 8; 0 for a reserved code) |
| burst_seq | output | 1 | 1 = interleaved burst order, 0 = sequential |
| cas_lat_x2 | output | 3 | CAS latency in half cycles (4, 5, 6; 0 if invalid) |
| cl_invalid | output | 1 | Stored latency code is not supported |
| dll_enable | output | 1 | DLL enabled |
| drive_reduced | output | 1 | Reduced output drive strength selected |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| reserved_err | output | 1 | One-cycle flag for a reserved mode-register write |

## Verification
The bench drives two copies of the block, one with each upper-bit limit, so that A12 must be ignored by one copy and rejected by the other. A decoder that checks a fixed bit range would give the same answer on both and fail one of them. The other corner cases are these:
- A8 set together with A7 or A9. A design that tests A8 alone would update the register instead of rejecting the command.
- Extended-register writes that carry upper bits. A design that applies the test-mode check here would raise a false error.
- Commands with `ba[1]` = 1, or with only some strobes low. A sloppy decoder would treat these as writes.
- Pulses checked on the cycle after the command and again on the cycle after that. A pulse that is held high, or one that comes a cycle late, is caught by one of the two checks.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

    // Field order matches A6..A0 so the address slice casts directly.
    typedef struct packed {
        logic [2:0] cl_code;
        logic       bt;
        logic [2:0] bl_code;
    } mode_reg_t;

    // Bit 1 = reduced drive, bit 0 = DLL off.
    typedef struct packed {
        logic drv_reduced;
        logic dll_off;
    } ext_reg_t;

    typedef enum logic [1:0] {
        UPPER_NORMAL,
        UPPER_DLL_RST,
        UPPER_RESERVED
    } upper_class_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_MODE,
        TGT_EXT
    } lmr_target_e;

    typedef struct packed {
        mode_reg_t mr;
        ext_reg_t  emr;
        logic      dll_rst_pulse;
        logic      rsv_err;
    } mrs_state_t;

    localparam mode_reg_t MR_RESET  = '{cl_code: 3'b010, bt: 1'b0, bl_code: 3'b010};
    localparam ext_reg_t  EMR_RESET = '{drv_reduced: 1'b0, dll_off: 1'b0};

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mrs_pkg::*;
(
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [1:0]  ba,
    output lmr_target_e target
);
    logic is_lmr;

    always_comb begin
        is_lmr = ~(cs_n | ras_n | cas_n | we_n);
        target = TGT_NONE;
        if (is_lmr) begin
            unique case (ba)
                2'b00:   target = TGT_MODE;
                2'b01:   target = TGT_EXT;
                default: target = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_upper_classify.sv
module ddr_upper_classify
    import ddr_mrs_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int HI_ADDR_BIT = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output upper_class_e      uclass
);
    localparam int UPPER_W = HI_ADDR_BIT - 6;
    localparam logic [UPPER_W-1:0] DLL_PAT = UPPER_W'(2);

    logic [UPPER_W-1:0] upper;
    logic               unused_lo;

    assign upper     = addr[HI_ADDR_BIT:7];
    assign unused_lo = ^addr[6:0];

    generate
        if (HI_ADDR_BIT < ADDR_W - 1) begin : g_hi_unused
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:HI_ADDR_BIT+1];
        end
    endgenerate

    always_comb begin
        if (upper == '0)
            uclass = UPPER_NORMAL;
        else if (upper == DLL_PAT)
            uclass = UPPER_DLL_RST;
        else
            uclass = UPPER_RESERVED;
    end
endmodule

// File: rtl/ddr_mode_fields.sv
module ddr_mode_fields
    import ddr_mrs_pkg::*;
(
    input  mode_reg_t  mr,
    output logic [3:0] burst_len,
    output logic       burst_seq,
    output logic [2:0] cas_lat_x2,
    output logic       cl_invalid
);
    always_comb begin
        unique case (mr.bl_code)
            3'b001:  burst_len = 4'd2;
            3'b010:  burst_len = 4'd4;
            3'b011:  burst_len = 4'd8;
            default: burst_len = 4'd0;
        endcase

        burst_seq = mr.bt;

        unique case (mr.cl_code)
            3'b010:  cas_lat_x2 = 3'd4;
            3'b110:  cas_lat_x2 = 3'd5;
            3'b011:  cas_lat_x2 = 3'd6;
            default: cas_lat_x2 = 3'd0;
        endcase

        cl_invalid = (cas_lat_x2 == 3'd0);
    end
endmodule

// File: rtl/ddr_mrs_decoder.sv
module ddr_mrs_decoder
    import ddr_mrs_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int HI_ADDR_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        burst_len,
    output logic              burst_seq,
    output logic [2:0]        cas_lat_x2,
    output logic              cl_invalid,
    output logic              dll_enable,
    output logic              drive_reduced,
    output logic              dll_reset_pulse,
    output logic              reserved_err
);
    lmr_target_e  target;
    upper_class_e uclass;
    mrs_state_t   st_d, st_q;

    ddr_cmd_decode u_cmd (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ba     (ba),
        .target (target)
    );

    ddr_upper_classify #(
        .ADDR_W      (ADDR_W),
        .HI_ADDR_BIT (HI_ADDR_BIT)
    ) u_cls (
        .addr   (addr),
        .uclass (uclass)
    );

    always_comb begin
        st_d               = st_q;
        st_d.dll_rst_pulse = 1'b0;
        st_d.rsv_err       = 1'b0;
        unique case (target)
            TGT_MODE: begin
                unique case (uclass)
                    UPPER_NORMAL: st_d.mr = mode_reg_t'(addr[6:0]);
                    UPPER_DLL_RST: begin
                        st_d.mr            = mode_reg_t'(addr[6:0]);
                        st_d.dll_rst_pulse = 1'b1;
                    end
                    default: st_d.rsv_err = 1'b1;
                endcase
            end
            TGT_EXT: st_d.emr = ext_reg_t'(addr[1:0]);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mr            <= MR_RESET;
            st_q.emr           <= EMR_RESET;
            st_q.dll_rst_pulse <= 1'b0;
            st_q.rsv_err       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    ddr_mode_fields u_fields (
        .mr         (st_q.mr),
        .burst_len  (burst_len),
        .burst_seq  (burst_seq),
        .cas_lat_x2 (cas_lat_x2),
        .cl_invalid (cl_invalid)
    );

    assign dll_enable      = ~st_q.emr.dll_off;
    assign drive_reduced   = st_q.emr.drv_reduced;
    assign dll_reset_pulse = st_q.dll_rst_pulse;
    assign reserved_err    = st_q.rsv_err;
endmodule

// File: rtl/ddr_mrs_decoder_chk.sv
module ddr_mrs_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] ba,
    input logic [3:0] burst_len,
    input logic       burst_seq,
    input logic [2:0] cas_lat_x2,
    input logic       cl_invalid,
    input logic       dll_enable,
    input logic       drive_reduced,
    input logic       dll_reset_pulse,
    input logic       reserved_err
);
    logic no_lmr;
    assign no_lmr = cs_n | ras_n | cas_n | we_n;

    // R2
    no_cmd_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_lmr |=> ($stable(burst_len) && $stable(burst_seq) && $stable(cas_lat_x2)
                    && $stable(dll_enable) && $stable(drive_reduced)
                    && !dll_reset_pulse && !reserved_err));

    // R9
    high_bank_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_lmr && ba[1]) |=> ($stable(burst_len) && $stable(cas_lat_x2)
                               && $stable(dll_enable) && !dll_reset_pulse && !reserved_err));

    // R5
    dll_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |=> !dll_reset_pulse || $past(!no_lmr && ba == 2'b00));

    // R6
    reserved_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_err |-> ($stable(burst_len) && $stable(burst_seq) && $stable(cas_lat_x2)));

    // R5
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dll_reset_pulse && reserved_err));

    // R3
    burst_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(burst_len) && !burst_len[0]);

    // R4
    cl_invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cl_invalid |-> (cas_lat_x2 == 3'd0));
endmodule

bind ddr_mrs_decoder ddr_mrs_decoder_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_n            (cs_n),
    .ras_n           (ras_n),
    .cas_n           (cas_n),
    .we_n            (we_n),
    .ba              (ba),
    .burst_len       (burst_len),
    .burst_seq       (burst_seq),
    .cas_lat_x2      (cas_lat_x2),
    .cl_invalid      (cl_invalid),
    .dll_enable      (dll_enable),
    .drive_reduced   (drive_reduced),
    .dll_reset_pulse (dll_reset_pulse),
    .reserved_err    (reserved_err)
);

// File: tb/tb_ddr_mrs_decoder.sv
module tb_ddr_mrs_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'b00;
    logic [AW-1:0] addr = '0;

    logic [3:0] bl_o [2];
    logic       bs_o [2];
    logic [2:0] cl_o [2];
    logic       ci_o [2];
    logic       de_o [2];
    logic       dr_o [2];
    logic       rp_o [2];
    logic       er_o [2];

    // model state per variant: 0 -> top bit 11, 1 -> top bit 12
    logic [6:0] m_mr  [2];
    logic [1:0] m_emr [2];
    logic       m_rp  [2];
    logic       m_er  [2];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_mrs_decoder #(.ADDR_W(AW), .HI_ADDR_BIT(11)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr),
        .burst_len(bl_o[0]), .burst_seq(bs_o[0]), .cas_lat_x2(cl_o[0]), .cl_invalid(ci_o[0]),
        .dll_enable(de_o[0]), .drive_reduced(dr_o[0]),
        .dll_reset_pulse(rp_o[0]), .reserved_err(er_o[0])
    );

    ddr_mrs_decoder #(.ADDR_W(AW), .HI_ADDR_BIT(12)) dut_wide (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr),
        .burst_len(bl_o[1]), .burst_seq(bs_o[1]), .cas_lat_x2(cl_o[1]), .cl_invalid(ci_o[1]),
        .dll_enable(de_o[1]), .drive_reduced(dr_o[1]),
        .dll_reset_pulse(rp_o[1]), .reserved_err(er_o[1])
    );

    function automatic int exp_bl(input logic [2:0] c);
        case (c)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cl(input logic [2:0] c);
        case (c)
            3'b010:  return 4;
            3'b110:  return 5;
            3'b011:  return 6;
            default: return 0;
        endcase
    endfunction

    // 0 normal, 1 dll reset, 2 reserved
    function automatic int classify(input logic [AW-1:0] a, input int hi);
        logic other = 1'b0;
        for (int i = 7; i <= hi; i++)
            if (i != 8) other |= a[i];
        if (other) return 2;
        return a[8] ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int v, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s (variant %0d): actual %0d expected %0d", req, what, v, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        for (int v = 0; v < 2; v++) begin
            check({ctx, " R3"}, "burst_len",       v, int'(bl_o[v]), exp_bl(m_mr[v][2:0]));
            check({ctx, " R3"}, "burst_seq",       v, int'(bs_o[v]), int'(m_mr[v][3]));
            check({ctx, " R4"}, "cas_lat_x2",      v, int'(cl_o[v]), exp_cl(m_mr[v][6:4]));
            check({ctx, " R4"}, "cl_invalid",      v, int'(ci_o[v]), int'(exp_cl(m_mr[v][6:4]) == 0));
            check({ctx, " R8"}, "dll_enable",      v, int'(de_o[v]), int'(!m_emr[v][0]));
            check({ctx, " R8"}, "drive_reduced",   v, int'(dr_o[v]), int'(m_emr[v][1]));
            check({ctx, " R5"}, "dll_reset_pulse", v, int'(rp_o[v]), int'(m_rp[v]));
            check({ctx, " R6"}, "reserved_err",    v, int'(er_o[v]), int'(m_er[v]));
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_mr[v] = 7'b010_0_010; m_emr[v] = 2'b00; m_rp[v] = 1'b0; m_er[v] = 1'b0;
        end
    endtask

    task automatic model_step();
        for (int v = 0; v < 2; v++) begin
            int k;
            m_rp[v] = 1'b0;
            m_er[v] = 1'b0;
            if (!(cs_n | ras_n | cas_n | we_n)) begin
                if (ba == 2'b00) begin
                    k = classify(addr, v ? 12 : 11);
                    if (k == 2) m_er[v] = 1'b1;
                    else begin
                        m_mr[v] = addr[6:0];
                        m_rp[v] = (k == 1);
                    end
                end else if (ba == 2'b01) begin
                    m_emr[v] = addr[1:0];
                end
            end
        end
    endtask

    // called just after a falling edge; checks at the next falling edge
    task automatic apply(input logic c, input logic r, input logic s, input logic w,
                         input logic [1:0] b, input logic [AW-1:0] a, input string ctx);
        cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; addr = a;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(ctx);
    endtask

    task automatic lmr(input logic [1:0] b, input logic [AW-1:0] a, input string ctx);
        apply(1'b0, 1'b0, 1'b0, 1'b0, b, a, ctx);
    endtask

    task automatic nop(input string ctx);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, '0, ctx);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3: BL8, interleaved, CL 2.5
        lmr(2'b00, 13'h006B, "R3 normal write");
        // R10: holds across idle cycles
        nop("R10 hold");
        nop("R10 hold");
        apply(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, '0, "R10 deselect");
        // R5: DLL reset with CL3 BL2
        lmr(2'b00, 13'h0131, "R5 dll reset");
        nop("R5 pulse drop");
        // R6: reserved patterns
        lmr(2'b00, 13'h00A2, "R6 A7 set");
        lmr(2'b00, 13'h0322, "R6 A8+A9");
        lmr(2'b00, 13'h0822, "R6 A11");
        nop("R6 err drop");
        // R7: A12 only
        lmr(2'b00, 13'h1022, "R7 A12");
        // R4: unsupported latency, R3: reserved burst code
        lmr(2'b00, 13'h0017, "R4 bad CL");
        // R8: extended writes, upper bits present
        lmr(2'b01, 13'h0003, "R8 dll off reduced");
        lmr(2'b01, 13'h0F82, "R8 upper bits");
        lmr(2'b01, 13'h0000, "R8 restore");
        // R9: high bank bits
        lmr(2'b10, 13'h006B, "R9 ba10");
        lmr(2'b11, 13'h0A03, "R9 ba11");
        // R2: partial strobe patterns
        apply(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 13'h0031, "R2 deselected");
        apply(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'h0031, "R2 activate");
        apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 13'h0003, "R2 write");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [3:0] st;
            int sel;
            a   = AW'($urandom);
            sel = int'($urandom % 4);
            case (sel)
                0: a[12:7] = 6'b000000;
                1: a[12:7] = 6'b000010;
                2: a[12:7] = 6'b100000;
                default: ;
            endcase
            st = ($urandom % 4 != 0) ? 4'b0000 : 4'($urandom);
            apply(st[3], st[2], st[1], st[0], 2'($urandom), a, "RND");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule